// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block produces the strobes of a multiplexed external memory bus for an eight-bit controller whose machine cycle has twelve oscillator clocks. That is six states of two phases each, numbered 0 to 11 here. Once per machine cycle it accepts one request from the core. A request is a code fetch, an external data read or an external data write. From it the block drives the address latch enable, the active-low program store strobe, the read strobe and the write strobe. It also drives the shared low address/data byte and its output enable, and the high address byte. Read or fetched bytes return to the core on a one-clock response pulse.

Requests use a valid/ready handshake. `req_ready` is high only in the last clock of each machine cycle, and a request is taken on the edge where `req_valid` and `req_ready` are both high. At any other time the core may hold or change its request, and that has no effect; this is the back-pressure the core sees. A cycle with no accepted request is an idle cycle. The `ale_off` input cuts emission from an idle bus: while it is set, idle cycles keep the latch enable low, but every fetch or data cycle still pulses it as usual.

Top module: `bus_cycle_seq`

## Requirements
- R1: A machine cycle lasts 12 clocks. `req_ready` is high only in phase 11, and a request is accepted only on an edge where `req_valid` and `req_ready` are both high. `req_kind` is encoded 00 fetch, 01 read, 1x write. Request inputs and `ale_off` have no effect at other times. After reset the block sits in phase 11.
- R2: In a fetch cycle, and in an idle cycle whose sampled `ale_off` is 0, `ale` is high exactly in phases 0-1 and 6-7. That gives two 2-clock pulses per machine cycle.
- R3: In a read or write cycle, `ale` is high in phases 0-1 only. The second pulse is omitted.
- R4: `ale_off` is sampled on the acceptance edge. When it is 1, an idle cycle keeps `ale` low, while fetch, read and write cycles pulse `ale` as in R2 and R3.
- R5: In a fetch cycle, `psen_n` is low in phases 3-5 and 9-11. That is 3 clocks, starting 1 clock after each ALE falling edge. In all other cycles it stays high.
- R6: In a read cycle `rd_n` is low in phases 5-10, and in a write cycle `wr_n` is low in phases 5-10. That is 6 clocks, starting 3 clocks after ALE falls. `rd_n` and `wr_n` are never both low, and `psen_n` stays high while either is low.
- R7: In any access cycle, `ad_oe` is 1 and `ad_out` carries `req_addr[7:0]` in phases 0-2. In a fetch cycle it carries `req_addr[7:0]`+1 (modulo 256) in phases 6-8.
- R8: In a write cycle, `ad_oe` is 1 and `ad_out` carries `req_wdata` in phases 3-11. This puts the data on the bus 2 clocks before WR falls and holds it 1 clock after WR rises. In every phase not named in R7 or R8, `ad_oe` is 0.
- R9: `addr_hi` equals `req_addr[15:8]` of the last accepted request for the whole of every cycle. It is 0 after reset.
- R10: `ad_in` is sampled on the last edge of phase 9 (state 5, phase 2) in a read cycle, and on the last edges of phases 5 and 11 in a fetch cycle. `rsp_valid` is high for one clock right after each sample, with the byte on `rsp_data`.
- R11: During reset, `ale`=0, `psen_n`=`rd_n`=`wr_n`=1, `ad_oe`=0, `rsp_valid`=0 and `addr_hi`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ale_off | input | 1 | Keep ALE low on idle cycles |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken this edge if valid |
| req_kind | input | 2 | 00 fetch, 01 read, 1x write |
| req_addr | input | 16 | External address |
| req_wdata | input | 8 | Write data |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Program store strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| ad_out | output | 8 | Low address/data bus, outgoing value |
| ad_oe | output | 1 | Drive enable for the low bus |
| ad_in | input | 8 | Low address/data bus, incoming value |
| addr_hi | output | 8 | High address byte |
| rsp_valid | output | 1 | Fetched or read byte valid |
| rsp_data | output | 8 | Fetched or read byte |

## Verification
Every strobe and bus output is registered from the next phase, so it takes its phase-0 value on the same edge that accepts the request. From then on it follows the phase count with no further lag. The bench therefore samples all outputs at every falling edge of each of the twelve phases and compares them with a per-phase table. This checks every transition position and pulse width. The response is due one clock after its sampling edge, in phase 6 and phase 0 of the next cycle for a fetch and in phase 10 for a read. The bench changes `ad_in` at each falling edge so that it knows exactly which byte each edge captured. Requests and `ale_off` are also changed at random phases in mid-cycle, to show that only the phase-11 edge counts.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
  localparam int PHASES = 12;
  localparam int PW     = 4;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_FETCH = 2'd1,
    CYC_READ  = 2'd2,
    CYC_WRITE = 2'd3
  } cyc_kind_t;

  typedef struct packed {
    cyc_kind_t   kind;
    logic        quiet;
    logic [15:0] addr;
    logic [7:0]  wdata;
  } cyc_ctx_t;
endpackage

// File: rtl/bus_phase_ctr.sv
module bus_phase_ctr
  import bus_seq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  output logic [PW-1:0] phase_q,
  output logic [PW-1:0] phase_d,
  output logic          last
);
  localparam logic [PW-1:0] LAST_PH = PW'(PHASES - 1);

  assign last    = (phase_q == LAST_PH);
  assign phase_d = last ? '0 : phase_q + PW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= LAST_PH;
    else        phase_q <= phase_d;
  end

  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !last); // R1
endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
  import bus_seq_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 16
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] phase_d,
  input  cyc_ctx_t      ctx_d,
  output logic          ale,
  output logic          psen_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic          ad_oe,
  output logic [DW-1:0] ad_out,
  output logic [AW-DW-1:0] addr_hi
);
  localparam int HALF      = PHASES / 2;
  localparam int ALE_W     = 2;
  localparam int ADDR_HOLD = ALE_W + 1;
  localparam int STB_START = ALE_W + 3;
  localparam int STB_LEN   = 6;
  localparam logic [PW-1:0] P_HALF  = PW'(HALF);
  localparam logic [PW-1:0] P_ALEW  = PW'(ALE_W);
  localparam logic [PW-1:0] P_HOLD  = PW'(ADDR_HOLD);
  localparam logic [PW-1:0] P_SBEG  = PW'(STB_START);
  localparam logic [PW-1:0] P_SEND  = PW'(STB_START + STB_LEN - 1);

  logic          slot_b;
  logic [PW-1:0] off;
  logic          is_fetch, is_read, is_write, is_idle;
  logic          ale_d, psen_d, rd_d, wr_d, oe_d;
  logic [DW-1:0] ad_d;
  logic          addr_win, data_win;

  always_comb begin
    slot_b   = (phase_d >= P_HALF);
    off      = slot_b ? phase_d - P_HALF : phase_d;
    is_fetch = (ctx_d.kind == CYC_FETCH);
    is_read  = (ctx_d.kind == CYC_READ);
    is_write = (ctx_d.kind == CYC_WRITE);
    is_idle  = (ctx_d.kind == CYC_IDLE);

    if (off < P_ALEW)
      ale_d = slot_b ? (is_fetch || (is_idle && !ctx_d.quiet))
                     : (!is_idle || !ctx_d.quiet);
    else
      ale_d = 1'b0;

    psen_d = !(is_fetch && off >= P_HOLD);
    rd_d   = !(is_read  && phase_d >= P_SBEG && phase_d <= P_SEND);
    wr_d   = !(is_write && phase_d >= P_SBEG && phase_d <= P_SEND);

    addr_win = !is_idle && off <= P_ALEW && (!slot_b || is_fetch);
    data_win = is_write && phase_d >= P_HOLD;
    oe_d     = addr_win || data_win;
    if (addr_win)
      ad_d = slot_b ? ctx_d.addr[DW-1:0] + DW'(1) : ctx_d.addr[DW-1:0];
    else if (data_win)
      ad_d = ctx_d.wdata;
    else
      ad_d = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ale     <= 1'b0;
      psen_n  <= 1'b1;
      rd_n    <= 1'b1;
      wr_n    <= 1'b1;
      ad_oe   <= 1'b0;
      ad_out  <= '0;
      addr_hi <= '0;
    end else begin
      ale     <= ale_d;
      psen_n  <= psen_d;
      rd_n    <= rd_d;
      wr_n    <= wr_d;
      ad_oe   <= oe_d;
      ad_out  <= ad_d;
      addr_hi <= ctx_d.addr[AW-1:DW];
    end
  end

  AST_ALE_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |=> ale); // R2
  AST_ALE_MAX_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> $past(ale, 2)); // R2
  AST_RDWR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n)); // R6
  AST_PSEN_QUIET_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> psen_n); // R6
  AST_WR_DATA_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe); // R8
endmodule

// File: rtl/bus_rd_capture.sv
module bus_rd_capture
  import bus_seq_pkg::*;
#(
  parameter int DW = 8
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] phase_q,
  input  cyc_kind_t     kind_q,
  input  logic [DW-1:0] ad_in,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);
  localparam logic [PW-1:0] P_FETCH_A = PW'(PHASES / 2 - 1);
  localparam logic [PW-1:0] P_FETCH_B = PW'(PHASES - 1);
  localparam logic [PW-1:0] P_READ    = PW'(9);

  logic take;
  assign take = (kind_q == CYC_FETCH && (phase_q == P_FETCH_A || phase_q == P_FETCH_B))
             || (kind_q == CYC_READ && phase_q == P_READ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= take;
      if (take) rsp_data <= ad_in;
    end
  end

  AST_RSP_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R10
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bus_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ale_off,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [1:0]  req_kind,
  input  logic [15:0] req_addr,
  input  logic [7:0]  req_wdata,
  output logic        ale,
  output logic        psen_n,
  output logic        rd_n,
  output logic        wr_n,
  output logic [7:0]  ad_out,
  output logic        ad_oe,
  input  logic [7:0]  ad_in,
  output logic [7:0]  addr_hi,
  output logic        rsp_valid,
  output logic [7:0]  rsp_data
);
  logic [PW-1:0] phase_q, phase_d;
  logic          last;
  cyc_ctx_t      ctx_q, ctx_d;

  bus_phase_ctr u_ctr (
    .clk(clk), .rst_n(rst_n),
    .phase_q(phase_q), .phase_d(phase_d), .last(last)
  );

  assign req_ready = last;

  always_comb begin
    ctx_d = ctx_q;
    if (last) begin
      ctx_d.kind  = CYC_IDLE;
      ctx_d.quiet = ale_off;
      if (req_valid) begin
        ctx_d.kind  = req_kind[1] ? CYC_WRITE : (req_kind[0] ? CYC_READ : CYC_FETCH);
        ctx_d.addr  = req_addr;
        ctx_d.wdata = req_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctx_q <= '{kind: CYC_IDLE, quiet: 1'b0, addr: '0, wdata: '0};
    else        ctx_q <= ctx_d;
  end

  bus_strobe_gen #(.DW(8), .AW(16)) u_stb (
    .clk(clk), .rst_n(rst_n), .phase_d(phase_d), .ctx_d(ctx_d),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .ad_oe(ad_oe), .ad_out(ad_out), .addr_hi(addr_hi)
  );

  bus_rd_capture #(.DW(8)) u_cap (
    .clk(clk), .rst_n(rst_n), .phase_q(phase_q), .kind_q(ctx_q.kind),
    .ad_in(ad_in), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  AST_HI_STABLE_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(last) |-> $stable(addr_hi)); // R9
endmodule

// File: tb/bus_cycle_seq_bench.sv
module bus_cycle_seq_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic ale_off, req_valid, req_ready;
  logic [1:0] req_kind;
  logic [15:0] req_addr;
  logic [7:0] req_wdata, ad_out, ad_in, addr_hi, rsp_data;
  logic ale, psen_n, rd_n, wr_n, ad_oe, rsp_valid;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  bus_cycle_seq u_bus_cycle_seq (
    .clk(clk), .rst_n(rst_n), .ale_off(ale_off), .req_valid(req_valid),
    .req_ready(req_ready), .req_kind(req_kind), .req_addr(req_addr),
    .req_wdata(req_wdata), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
    .wr_n(wr_n), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .addr_hi(addr_hi), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  // kinds used by the bench: 0 idle, 1 fetch, 2 read, 3 write
  task automatic check(input string tag, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [7:0] bus_byte(input int c, input int p);
    return 8'((c * 37 + p * 11 + 5) & 255);
  endfunction

  function automatic int exp_ale(input int k, input int q, input int p);
    bit early = (p == 0 || p == 1);
    bit late  = (p == 6 || p == 7);
    case (k)
      1:       return int'(early || late);
      2, 3:    return int'(early);
      default: return int'(q == 0 && (early || late));
    endcase
  endfunction

  function automatic int exp_oe(input int k, input int p);
    if (k != 0 && p <= 2) return 1;
    if (k == 1 && p >= 6 && p <= 8) return 1;
    if (k == 3 && p >= 3) return 1;
    return 0;
  endfunction

  function automatic int exp_ad(input int k, input int p, input int a, input int w);
    if (p <= 2) return a & 255;
    if (k == 1) return (a + 1) & 255;
    return w;
  endfunction

  // plan for a cycle
  int pl_k, pl_q, pl_a, pl_w;
  task automatic make_plan(input int c);
    case (c)
      0: begin pl_k = 1; pl_q = 0; pl_a = 16'h1234; end
      1: begin pl_k = 2; pl_q = 0; pl_a = 16'hA055; end
      2: begin pl_k = 3; pl_q = 0; pl_a = 16'h7F0F; end
      3: begin pl_k = 0; pl_q = 0; pl_a = 0; end
      4: begin pl_k = 0; pl_q = 1; pl_a = 0; end
      5: begin pl_k = 1; pl_q = 1; pl_a = 16'h40FF; end
      6: begin pl_k = 2; pl_q = 1; pl_a = 16'hC3C3; end
      7: begin pl_k = 3; pl_q = 1; pl_a = 16'h0001; end
      default: begin
        pl_k = int'($urandom % 4);
        pl_q = int'($urandom % 2);
        pl_a = int'($urandom % 65536);
      end
    endcase
    pl_w = int'($urandom % 256);
  endtask

  task automatic drive_plan();
    ale_off   = pl_q[0];
    req_valid = (pl_k != 0);
    req_addr  = 16'(pl_a);
    req_wdata = 8'(pl_w);
    case (pl_k)
      1: req_kind = 2'b00;
      2: req_kind = 2'b01;
      3: req_kind = ($urandom % 2 == 0) ? 2'b10 : 2'b11;
      default: req_kind = 2'(($urandom % 4));
    endcase
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int cur_k, cur_q, cur_a, cur_w, hi_last, pt;
    bit prev_fetch;
    rst_n = 1'b0; ale_off = 1'b0; req_valid = 1'b0; req_kind = '0;
    req_addr = '0; req_wdata = '0; ad_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    check("R11 ale", int'(ale), 0);
    check("R11 psen_n", int'(psen_n), 1);
    check("R11 rd_n", int'(rd_n), 1);
    check("R11 wr_n", int'(wr_n), 1);
    check("R11 ad_oe", int'(ad_oe), 0);
    check("R11 rsp_valid", int'(rsp_valid), 0);
    check("R11 addr_hi", int'(addr_hi), 0);
    rst_n = 1'b1;
    check("R1 ready after reset", int'(req_ready), 1);
    hi_last = 0;
    prev_fetch = 1'b0;
    make_plan(0);
    drive_plan();
    cur_k = pl_k; cur_q = pl_q; cur_a = pl_a; cur_w = pl_w;
    for (int c = 0; c < 80; c++) begin
      @(posedge clk);
      if (cur_k != 0) hi_last = (cur_a >> 8) & 255;
      make_plan(c + 1);
      pt = int'($urandom % 12);
      for (int p = 0; p < 12; p++) begin
        @(negedge clk);
        check("R1 req_ready", int'(req_ready), int'(p == 11));
        check((cur_k == 2 || cur_k == 3) ? "R3 ale" : (cur_q != 0 ? "R4 ale" : "R2 ale"),
              int'(ale), exp_ale(cur_k, cur_q, p));
        check("R5 psen_n", int'(psen_n),
              int'(!(cur_k == 1 && (p % 6) >= 3)));
        check("R6 rd_n", int'(rd_n), int'(!(cur_k == 2 && p >= 5 && p <= 10)));
        check("R6 wr_n", int'(wr_n), int'(!(cur_k == 3 && p >= 5 && p <= 10)));
        check("R7 R8 ad_oe", int'(ad_oe), exp_oe(cur_k, p));
        if (exp_oe(cur_k, p) != 0)
          check(p >= 3 && cur_k == 3 ? "R8 ad_out" : "R7 ad_out",
                int'(ad_out), exp_ad(cur_k, p, cur_a, cur_w));
        check("R9 addr_hi", int'(addr_hi), hi_last);
        if (p == 0)
          check("R10 rsp_valid", int'(rsp_valid), int'(prev_fetch));
        else
          check("R10 rsp_valid", int'(rsp_valid),
                int'((p == 6 && cur_k == 1) || (p == 10 && cur_k == 2)));
        if (rsp_valid) begin
          if (p == 0)       check("R10 rsp_data", int'(rsp_data), int'(bus_byte(c - 1, 11)));
          else if (p == 6)  check("R10 rsp_data", int'(rsp_data), int'(bus_byte(c, 5)));
          else if (p == 10) check("R10 rsp_data", int'(rsp_data), int'(bus_byte(c, 9)));
        end
        ad_in = bus_byte(c, p);
        // R1: junk before the real request must be ignored
        if (p == 0 && pt > 0) begin
          req_valid = 1'($urandom % 2);
          req_kind  = 2'($urandom % 4);
          req_addr  = 16'($urandom % 65536);
          ale_off   = 1'($urandom % 2);
        end
        if (p == pt) drive_plan();
      end
      prev_fetch = (cur_k == 1);
      cur_k = pl_k; cur_q = pl_q; cur_a = pl_a; cur_w = pl_w;
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule